// File: doc/BRIEF.md
# PLL Lock-Loss Monitor with Hold Stretch

This block watches the phase-error pulse produced by a PLL phase detector. It measures the width of each pulse in reference-clock cycles and compares it with a tolerance picked by a two-bit code. Any pulse longer than the tolerance counts as loss of lock. The lock-loss indication is then held for a programmable stretch time, 2 ms by default. Every new over-tolerance pulse restarts the hold. Before it is measured, the phase-error input passes through a two-flop synchroniser.

A three-bit select code chooses what drives an open-drain status pin. The choices are the lock-loss indication, the general-purpose counter's done flag, the raw counter input, or a released pin. The pin is modelled as a pull-low enable: 1 pulls the pin low and 0 releases it, so a released pin reads high through the external pull-up. A two-bit pump code controls an auxiliary fast-lock charge pump. It can hold the pump in high impedance, run it only while lock is lost, or run it all the time. The pin and pump outputs are registered.

Top module: `pll_unlock_monitor`

## Requirements
- R1: While `rst_n` is low, `pinPullLow` and `auxPumpEn` are both 0.
- R2: With `tolSel` = 00, no phase-error pulse of any length causes lock loss, so the pin is released (select 000) and the pump stays off (pump code 10).
- R3: With `tolSel` = 01, the synchronised phase-error pulse drives the lock-loss indication directly. The pin is pulled low while the error is high and released within four cycles after it ends, with no stretch. This holds even for a 2-cycle pulse.
- R4: With `tolSel` = 10, the threshold is CLK_HZ/2e6 cycles (4 at 8 MHz). A pulse sampled high on exactly that many clock edges does not flag lock loss. One more cycle does.
- R5: With `tolSel` = 11, the threshold is CLK_HZ/1e6 cycles (8 at 8 MHz), with the same boundary rule as R4.
- R6: In codes 10 and 11, a flagged lock loss stays on the output for STRETCH_US microseconds (CLK_HZ/1e6 × STRETCH_US cycles) after the last over-tolerance cycle, and is then removed.
- R7: An over-tolerance pulse that arrives during a running hold restarts the full hold time.
- R8: Pin select {mode,sel1,sel0} works as follows. 000 pulls the pin low on lock loss. x10 pulls it low while `cntDone` is 0. x11 pulls it low while `cntIn` is 0. 100 and x01 release the pin, even during lock loss.
- R9: Pump code 0x keeps `auxPumpEn` at 0 even during lock loss. Code 10 sets it equal to the lock-loss indication. Code 11 holds it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phaseErr | input | 1 | Phase-error pulse from the phase detector (asynchronous) |
| tolSel | input | 2 | Tolerance code: 00 off, 01 raw, 10 half-microsecond, 11 one-microsecond |
| pinSel | input | 3 | Status-pin source select {mode,sel1,sel0} |
| pumpSel | input | 2 | Auxiliary pump code: 0x high-Z, 10 while unlocked, 11 always |
| cntDone | input | 1 | General-purpose counter done flag |
| cntIn | input | 1 | Raw general-purpose counter input |
| pinPullLow | output | 1 | Open-drain enable: 1 pulls the status pin low |
| auxPumpEn | output | 1 | Auxiliary charge pump drive enable (0 = high impedance) |

## Verification
A fresh over-tolerance pulse can land in the same cycle that an earlier hold is about to run out. The reload must win, so the output must not show a one-cycle release. The bench provokes this with a second long pulse half-way through a hold. It then samples the pin and the pump enable at a point past the moment the first hold would have expired, and requires both to still be asserted. A later sample, after the second hold has fully elapsed, must show both released. Pump gating and pin pull-low are derived from the same indication, so the bench also changes the pump and pin codes while a hold is running. It checks that each output follows its own code independently.

// File: rtl/pll_unlock_pkg.sv
package pll_unlock_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic measureEn;  // width measurement active (tolerance codes 1x)
    logic longThr;    // select the one-microsecond threshold
    logic holdClear;  // drop any running hold
  } ulStrobe_t;

  typedef enum logic [1:0] {
    SRC_UNLOCK = 2'd0,
    SRC_DONE   = 2'd1,
    SRC_INPUT  = 2'd2,
    SRC_FLOAT  = 2'd3
  } pinSrc_e;

  function automatic pinSrc_e decodePinSel(input logic [2:0] sel);
    pinSrc_e src;
    casez (sel)
      3'b000:  src = SRC_UNLOCK;
      3'b?10:  src = SRC_DONE;
      3'b?11:  src = SRC_INPUT;
      default: src = SRC_FLOAT;  // 100 open, x01 reserved
    endcase
    return src;
  endfunction

endpackage

// File: rtl/pll_unlock_datapath.sv
module pll_unlock_datapath
  import pll_unlock_pkg::*;
#(
  parameter int CLK_HZ      = 8_000_000,
  parameter int STRETCH_US  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      phaseErr,
  input  ulStrobe_t strobe,
  output logic      phSync,
  output logic      holdActive
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int THR_SHORT  = CLK_HZ / 2_000_000;
  localparam int THR_LONG   = CYC_PER_US;
  localparam int HOLD_CYC   = CYC_PER_US * STRETCH_US;
  localparam int WID_W      = $clog2(THR_LONG + 1);
  localparam int HOLD_W     = $clog2(HOLD_CYC + 1);

  // Input synchroniser chain
  logic [SYNC_STAGES-1:0] syncQ;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ[0] <= 1'b0;
        else        syncQ[0] <= phaseErr;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ[i] <= 1'b0;
        else        syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign phSync = syncQ[SYNC_STAGES-1];

  // Pulse width counter, saturating at the longest threshold
  logic [WID_W-1:0] widthCnt;
  logic [WID_W-1:0] thrCycles;
  logic             overTol;

  assign thrCycles = strobe.longThr ? WID_W'(THR_LONG) : WID_W'(THR_SHORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widthCnt <= '0;
    end else if (phSync && strobe.measureEn) begin
      if (widthCnt != WID_W'(THR_LONG)) widthCnt <= widthCnt + 1'b1;
    end else begin
      widthCnt <= '0;
    end
  end

  assign overTol = strobe.measureEn && phSync && (widthCnt >= thrCycles);

  // Hold stretcher, reloaded by every over-tolerance cycle
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (strobe.holdClear) begin
      holdCnt <= '0;
    end else if (overTol) begin
      holdCnt <= HOLD_W'(HOLD_CYC);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign holdActive = (holdCnt != '0);

  // R5: counter never passes the largest threshold
  p_width_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    widthCnt <= WID_W'(THR_LONG));

  // R4: an over-tolerance cycle needs the error to have been high before
  p_event_needs_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overTol |-> $past(phSync));

  // R6: an over-tolerance cycle leads to an active hold
  p_hold_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overTol |=> holdActive);

  // R2: clearing the hold empties it
  p_hold_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdClear |=> !holdActive);

endmodule

// File: rtl/pll_unlock_control.sv
module pll_unlock_control
  import pll_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tolSel,
  input  logic [2:0] pinSel,
  input  logic [1:0] pumpSel,
  input  logic       cntDone,
  input  logic       cntIn,
  input  logic       phSync,
  input  logic       holdActive,
  output ulStrobe_t  strobe,
  output logic       pinPullLow,
  output logic       auxPumpEn
);

  // Strobes toward the datapath
  always_comb begin
    strobe.measureEn = tolSel[1];
    strobe.longThr   = tolSel[0];
    strobe.holdClear = ~tolSel[1];
  end

  // Lock-loss indication by tolerance mode
  logic unlockInd;

  always_comb begin
    case (tolSel)
      2'b00:   unlockInd = 1'b0;
      2'b01:   unlockInd = phSync;
      default: unlockInd = holdActive;
    endcase
  end

  // Status pin source
  pinSrc_e pinSrc;
  logic    pullNext;

  assign pinSrc = decodePinSel(pinSel);

  always_comb begin
    case (pinSrc)
      SRC_UNLOCK: pullNext = unlockInd;
      SRC_DONE:   pullNext = ~cntDone;
      SRC_INPUT:  pullNext = ~cntIn;
      default:    pullNext = 1'b0;
    endcase
  end

  // Auxiliary pump enable
  logic pumpNext;

  always_comb begin
    case (pumpSel)
      2'b10:   pumpNext = unlockInd;
      2'b11:   pumpNext = 1'b1;
      default: pumpNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinPullLow <= 1'b0;
      auxPumpEn  <= 1'b0;
    end else begin
      pinPullLow <= pullNext;
      auxPumpEn  <= pumpNext;
    end
  end

  // R2: detection off leaves the pin released on select 000
  p_off_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tolSel == 2'b00 && pinSel == 3'b000) |=> !pinPullLow);

  // R8: reserved and open selects never pull the pin
  p_reserved_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pinSel[1:0] == 2'b01 || pinSel == 3'b100) |=> !pinPullLow);

  // R9: pump high impedance when code MSB is 0
  p_pump_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pumpSel[1] |=> !auxPumpEn);

  // R9: pump always on with code 11
  p_pump_cont_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pumpSel == 2'b11) |=> auxPumpEn);

  // R3: raw mode follows the synchronised error on select 000
  p_raw_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tolSel == 2'b01 && pinSel == 3'b000 && phSync) |=> pinPullLow);

endmodule

// File: rtl/pll_unlock_monitor.sv
module pll_unlock_monitor
  import pll_unlock_pkg::*;
#(
  parameter int CLK_HZ      = 8_000_000,
  parameter int STRETCH_US  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phaseErr,
  input  logic [1:0] tolSel,
  input  logic [2:0] pinSel,
  input  logic [1:0] pumpSel,
  input  logic       cntDone,
  input  logic       cntIn,
  output logic       pinPullLow,
  output logic       auxPumpEn
);

  ulStrobe_t strobe;
  logic      phSync;
  logic      holdActive;

  pll_unlock_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tolSel     (tolSel),
    .pinSel     (pinSel),
    .pumpSel    (pumpSel),
    .cntDone    (cntDone),
    .cntIn      (cntIn),
    .phSync     (phSync),
    .holdActive (holdActive),
    .strobe     (strobe),
    .pinPullLow (pinPullLow),
    .auxPumpEn  (auxPumpEn)
  );

  pll_unlock_datapath #(
    .CLK_HZ      (CLK_HZ),
    .STRETCH_US  (STRETCH_US),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .phaseErr   (phaseErr),
    .strobe     (strobe),
    .phSync     (phSync),
    .holdActive (holdActive)
  );

endmodule

// File: tb/sim_pll_unlock_monitor.sv
module sim_pll_unlock_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8_000_000;
  localparam int STRETCH_US = 50;
  localparam int THR_S      = CLK_HZ / 2_000_000;
  localparam int THR_L      = CLK_HZ / 1_000_000;
  localparam int HOLD       = (CLK_HZ / 1_000_000) * STRETCH_US;
  localparam int WATCHDOG   = 100_000;

  // {pinSel[2:0], cntDone, cntIn, expected pinPullLow} with detection off
  localparam logic [5:0] VEC [10] = '{
    6'b000_11_0, 6'b010_10_0, 6'b010_01_1, 6'b110_00_1, 6'b011_01_0,
    6'b011_10_1, 6'b111_10_1, 6'b100_00_0, 6'b001_00_0, 6'b101_00_0
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phaseErr = 1'b0;
  logic [1:0] tolSel = 2'b00;
  logic [2:0] pinSel = 3'b000;
  logic [1:0] pumpSel = 2'b00;
  logic       cntDone = 1'b0;
  logic       cntIn = 1'b0;
  logic       pinPullLow;
  logic       auxPumpEn;

  int checks = 0;
  int fails = 0;
  int cycCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_unlock_monitor #(
    .CLK_HZ     (CLK_HZ),
    .STRETCH_US (STRETCH_US)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .phaseErr   (phaseErr),
    .tolSel     (tolSel),
    .pinSel     (pinSel),
    .pumpSel    (pumpSel),
    .cntDone    (cntDone),
    .cntIn      (cntIn),
    .pinPullLow (pinPullLow),
    .auxPumpEn  (auxPumpEn)
  );

  always @(posedge clk) begin
    cycCount++;
    if (cycCount == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycCount);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    phaseErr = 1'b1;
    cyc(n);
    phaseErr = 1'b0;
  endtask

  initial begin
    // R1: reset state
    cyc(5);
    chk("R1 pin", pinPullLow, 1'b0);
    chk("R1 pump", auxPumpEn, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    // R8: pin source table
    for (int i = 0; i < 10; i++) begin
      pinSel  = VEC[i][5:3];
      cntDone = VEC[i][2];
      cntIn   = VEC[i][1];
      cyc(2);
      chk("R8 select", pinPullLow, VEC[i][0]);
    end
    pinSel = 3'b000;
    cntDone = 1'b0;
    cntIn = 1'b0;

    // R2: detection off
    tolSel = 2'b00;
    pumpSel = 2'b10;
    pulse(20);
    cyc(2);
    chk("R2 pin", pinPullLow, 1'b0);
    chk("R2 pump", auxPumpEn, 1'b0);
    pumpSel = 2'b00;

    // R3: raw passthrough
    tolSel = 2'b01;
    phaseErr = 1'b1;
    cyc(3);
    chk("R3 low", pinPullLow, 1'b1);
    cyc(3);
    chk("R3 held", pinPullLow, 1'b1);
    phaseErr = 1'b0;
    cyc(3);
    chk("R3 release", pinPullLow, 1'b0);
    pulse(2);
    cyc(1);
    chk("R3 short", pinPullLow, 1'b1);
    cyc(4);
    chk("R3 no stretch", pinPullLow, 1'b0);

    // R4: half-microsecond threshold boundary
    tolSel = 2'b10;
    pulse(THR_S);
    cyc(6);
    chk("R4 at threshold", pinPullLow, 1'b0);
    pulse(THR_S + 1);
    cyc(5);
    chk("R4 over threshold", pinPullLow, 1'b1);
    cyc(HOLD - 10);
    chk("R6 still held", pinPullLow, 1'b1);
    cyc(14);
    chk("R6 expired", pinPullLow, 1'b0);

    // R5: one-microsecond threshold boundary
    tolSel = 2'b11;
    pulse(THR_L);
    cyc(6);
    chk("R5 at threshold", pinPullLow, 1'b0);
    pulse(THR_L + 1);
    cyc(5);
    chk("R5 over threshold", pinPullLow, 1'b1);

    // R9 and R8 while a hold runs
    pumpSel = 2'b10;
    cyc(2);
    chk("R9 pump on unlock", auxPumpEn, 1'b1);
    pumpSel = 2'b00;
    cyc(2);
    chk("R9 pump hiz", auxPumpEn, 1'b0);
    chk("R9 pin unaffected", pinPullLow, 1'b1);
    pinSel = 3'b100;
    cyc(2);
    chk("R8 open during unlock", pinPullLow, 1'b0);
    pinSel = 3'b000;

    // R7: restart of the hold by a second pulse
    tolSel = 2'b00;
    cyc(2);
    tolSel = 2'b11;
    pumpSel = 2'b10;
    pulse(12);
    cyc(HOLD / 2);
    pulse(12);
    cyc(HOLD - 4);
    chk("R7 pin restarted", pinPullLow, 1'b1);
    chk("R7 pump restarted", auxPumpEn, 1'b1);
    cyc(12);
    chk("R7 pin released", pinPullLow, 1'b0);
    chk("R9 pump off when locked", auxPumpEn, 1'b0);

    // R9: continuous pump
    pumpSel = 2'b11;
    cyc(2);
    chk("R9 pump continuous", auxPumpEn, 1'b1);
    chk("R9 pin idle", pinPullLow, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule